// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller sits on the host side of an asynchronous 16-bit NOR-style flash and erases a run of consecutive blocks. A single-cycle start request supplies the first block index, how many blocks to erase and a flag that selects the error-check policy. The controller then drives the flash chip-enable, output-enable and write-enable strobes together with the address and data buses.

For each block it writes the two erase command words to that block and reads the status word until the device reports ready. Depending on the policy, it either inspects the error flags after every block or only once, after the final block. When the run ends, it writes the command that returns the array to normal reads. It then pulses done and presents a pass flag, a three-bit error code and the index of the block it blames.

If the previous run ended with any error, the next run first writes the clear-status command. This ensures that sticky error flags left in the device do not block or taint the new erase.

Top module: `fbe_sequencer`

## Requirements
- R1: For each block, the sequencer writes 0x0020 and then 0x00D0. Both writes go to the address whose bits [ADDR_W-1:BLK_SHIFT] hold the block index and whose low bits are zero. Blocks are erased in ascending order, starting at the requested index.
- R2: After the confirm write, the sequencer reads status repeatedly. CE# and OE# both return high between reads. It leaves polling only after a read with bit 7 set.
- R3: A write drives CE# low with address and data stable for SETUP_CLKS clocks before WE# falls. WE# then stays low for PULSE_CLKS clocks. WE# and OE# are never low together.
- R4: In per-block check mode, a ready status is decoded with a fixed priority. Bit 1 gives code 1, otherwise bit 3 gives code 2, otherwise bit 5 gives code 3. A nonzero code stops the run, and the failing block index is reported.
- R5: In deferred mode, the error bits are decoded only after the last block, and every requested block is erased. On error, the reported index is the last block.
- R6: If POLL_LIMIT consecutive reads show bit 7 clear, the run stops with code 4, and the reported index is the polled block.
- R7: Every run ends with a write of 0x00FF, including runs that stop on an error or a timeout.
- R8: If the previous run ended with a nonzero code, the new run writes 0x0050 before any other write. Otherwise it writes no 0x0050.
- R9: `done_o` is a one-cycle pulse that follows the final write. When it fires, `busy_o` is low. `pass_o` is 1 exactly when the code is 0. The results hold until the next start.
- R10: A block count of zero is treated as one block.
- R11: Under reset, CE#, OE# and WE# are high. The data bus is released. `busy_o`, `done_o`, `pass_o` and the error code are 0, and no clear-status write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| first_blk_i | input | ADDR_W-BLK_SHIFT | Index of the first block |
| blk_cnt_i | input | CNT_W | Number of blocks (0 means 1) |
| check_each_i | input | 1 | 1: decode errors after each block; 0: only after the last |
| f_addr_o | output | ADDR_W | Flash address |
| f_dq_i | input | DATA_W | Flash data from device |
| f_dq_o | output | DATA_W | Flash data to device |
| f_dq_oe_o | output | 1 | Drive enable for f_dq_o |
| f_ce_n_o | output | 1 | Chip enable, active low |
| f_oe_n_o | output | 1 | Output enable, active low |
| f_we_n_o | output | 1 | Write enable, active low |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (one cycle) |
| pass_o | output | 1 | Last run ended with code 0 |
| err_o | output | 3 | 0 none, 1 locked, 2 voltage, 3 erase fail, 4 timeout |
| fail_blk_o | output | ADDR_W-BLK_SHIFT | Block blamed for the error |

## Verification
A corrupt phase counter in the bus engine shows up on the next write as a wrong setup or strobe width on WE#. It can also appear as a missing high gap on OE# between status reads, visible within one bus cycle.

A sequencer state that skips or repeats a step appears at the device model. It shows as a confirm without a preceding setup, a wrong block order, or a wrong read count before the done pulse.

A stale clear-status flag is exposed on the very first write of the next run. A wrong priority decode is exposed in the error code reported with that run's done pulse.

// File: rtl/fbe_pkg.sv
package fbe_pkg;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_ARRAY_MODE  = 8'hFF;

    localparam int BIT_READY = 7;
    localparam int BIT_LOCK  = 1;
    localparam int BIT_VOLT  = 3;
    localparam int BIT_FAIL  = 5;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_LOCKED  = 3'd1,
        ERR_VOLT    = 3'd2,
        ERR_ERASE   = 3'd3,
        ERR_TIMEOUT = 3'd4
    } err_code_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
    } bus_phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CLEAR, SQ_SETUP, SQ_CONFIRM, SQ_POLL, SQ_EXIT
    } seq_state_e;

    // Priority decode of a ready status byte.
    function automatic err_code_e classify(input logic [7:0] st);
        if (st[BIT_LOCK])      return ERR_LOCKED;
        else if (st[BIT_VOLT]) return ERR_VOLT;
        else if (st[BIT_FAIL]) return ERR_ERASE;
        return ERR_NONE;
    endfunction

endpackage

// File: rtl/fbe_bus_cycle.sv
module fbe_bus_cycle
    import fbe_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 16,
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] f_addr_o,
    input  logic [DATA_W-1:0] f_dq_i,
    output logic [DATA_W-1:0] f_dq_o,
    output logic              f_dq_oe_o,
    output logic              f_ce_n_o,
    output logic              f_oe_n_o,
    output logic              f_we_n_o
);
    localparam int CW = $clog2(SETUP_CLKS + PULSE_CLKS + HOLD_CLKS + 1);

    bus_phase_e        ph;
    logic [CW-1:0]     cnt;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_o <= '0;
            ack_o   <= 1'b0;
        end else begin
            ack_o <= 1'b0;
            case (ph)
                PH_IDLE: if (req_i) begin
                    wr_q    <= wr_i;
                    addr_q  <= addr_i;
                    wdata_q <= wdata_i;
                    cnt     <= CW'(SETUP_CLKS - 1);
                    ph      <= PH_SETUP;
                end
                PH_SETUP: if (cnt == '0) begin
                    cnt <= CW'(PULSE_CLKS - 1);
                    ph  <= PH_STROBE;
                end else cnt <= cnt - 1'b1;
                PH_STROBE: if (cnt == '0) begin
                    if (!wr_q) rdata_o <= f_dq_i;
                    cnt <= CW'(HOLD_CLKS - 1);
                    ph  <= PH_HOLD;
                end else cnt <= cnt - 1'b1;
                PH_HOLD: if (cnt == '0) begin
                    ack_o <= 1'b1;
                    ph    <= PH_IDLE;
                end else cnt <= cnt - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign f_addr_o  = addr_q;
    assign f_dq_o    = wdata_q;
    assign f_dq_oe_o = (ph != PH_IDLE) && wr_q;
    assign f_ce_n_o  = (ph == PH_IDLE);
    assign f_we_n_o  = !((ph == PH_STROBE) && wr_q);
    assign f_oe_n_o  = !((ph == PH_STROBE) && !wr_q);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(!f_we_n_o && !f_oe_n_o));
    p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
        (!f_we_n_o || !f_oe_n_o) |-> !f_ce_n_o);
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!f_ce_n_o && $past(!f_ce_n_o)) |-> $stable(f_addr_o));
    p_gap_between_r2: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> f_ce_n_o);

endmodule

// File: rtl/fbe_status_eval.sv
module fbe_status_eval
    import fbe_pkg::*;
(
    input  logic [7:0] status_i,
    output logic       ready_o,
    output err_code_e  code_o
);
    always_comb begin
        ready_o = status_i[BIT_READY];
        code_o  = classify(status_i);
    end
endmodule

// File: rtl/fbe_sequencer.sv
module fbe_sequencer
    import fbe_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 16,
    parameter int BLK_SHIFT  = 15,
    parameter int CNT_W      = 8,
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 1,
    parameter int POLL_LIMIT = 1024
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [ADDR_W-BLK_SHIFT-1:0] first_blk_i,
    input  logic [CNT_W-1:0]            blk_cnt_i,
    input  logic                        check_each_i,
    output logic [ADDR_W-1:0]           f_addr_o,
    input  logic [DATA_W-1:0]           f_dq_i,
    output logic [DATA_W-1:0]           f_dq_o,
    output logic                        f_dq_oe_o,
    output logic                        f_ce_n_o,
    output logic                        f_oe_n_o,
    output logic                        f_we_n_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        pass_o,
    output logic [2:0]                  err_o,
    output logic [ADDR_W-BLK_SHIFT-1:0] fail_blk_o
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;
    localparam int PC_W  = $clog2(POLL_LIMIT + 1);

    seq_state_e        st;
    logic              pend;
    logic [BLK_W-1:0]  cur_blk;
    logic [CNT_W-1:0]  remaining;
    logic [PC_W-1:0]   poll_cnt;
    logic              each_q;
    logic              owe_clear;
    err_code_e         err_q;
    logic              pass_q;
    logic              done_q;
    logic [BLK_W-1:0]  fail_q;

    logic              bus_req, bus_wr, bus_ack;
    logic [7:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_rdata;
    logic              ev_ready;
    err_code_e         ev_code;
    logic              last_blk;

    always_comb begin
        bus_req  = (st != SQ_IDLE) && !pend;
        bus_wr   = (st != SQ_POLL);
        bus_addr = {cur_blk, {BLK_SHIFT{1'b0}}};
        case (st)
            SQ_CLEAR:   bus_cmd = CMD_CLR_STATUS;
            SQ_SETUP:   bus_cmd = CMD_ERASE_SETUP;
            SQ_CONFIRM: bus_cmd = CMD_ERASE_GO;
            default:    bus_cmd = CMD_ARRAY_MODE;
        endcase
        last_blk = (remaining == CNT_W'(1));
    end

    fbe_bus_cycle #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CLKS(SETUP_CLKS),
        .PULSE_CLKS(PULSE_CLKS), .HOLD_CLKS(HOLD_CLKS)
    ) u_bus (
        .clk(clk), .rst(rst),
        .req_i(bus_req), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i({{(DATA_W-8){1'b0}}, bus_cmd}),
        .ack_o(bus_ack), .rdata_o(bus_rdata),
        .f_addr_o(f_addr_o), .f_dq_i(f_dq_i), .f_dq_o(f_dq_o),
        .f_dq_oe_o(f_dq_oe_o), .f_ce_n_o(f_ce_n_o),
        .f_oe_n_o(f_oe_n_o), .f_we_n_o(f_we_n_o)
    );

    fbe_status_eval u_eval (
        .status_i(bus_rdata[7:0]), .ready_o(ev_ready), .code_o(ev_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            pend      <= 1'b0;
            cur_blk   <= '0;
            remaining <= '0;
            poll_cnt  <= '0;
            each_q    <= 1'b0;
            owe_clear <= 1'b0;
            err_q     <= ERR_NONE;
            pass_q    <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (bus_req) pend <= 1'b1;
            case (st)
                SQ_IDLE: if (start_i) begin
                    cur_blk   <= first_blk_i;
                    remaining <= (blk_cnt_i == '0) ? CNT_W'(1) : blk_cnt_i;
                    each_q    <= check_each_i;
                    err_q     <= ERR_NONE;
                    pass_q    <= 1'b0;
                    fail_q    <= '0;
                    st        <= owe_clear ? SQ_CLEAR : SQ_SETUP;
                end
                SQ_CLEAR: if (bus_ack) begin
                    pend      <= 1'b0;
                    owe_clear <= 1'b0;
                    st        <= SQ_SETUP;
                end
                SQ_SETUP: if (bus_ack) begin
                    pend <= 1'b0;
                    st   <= SQ_CONFIRM;
                end
                SQ_CONFIRM: if (bus_ack) begin
                    pend     <= 1'b0;
                    poll_cnt <= '0;
                    st       <= SQ_POLL;
                end
                SQ_POLL: if (bus_ack) begin
                    pend <= 1'b0;
                    if (!ev_ready) begin
                        if (poll_cnt == PC_W'(POLL_LIMIT - 1)) begin
                            err_q  <= ERR_TIMEOUT;
                            fail_q <= cur_blk;
                            st     <= SQ_EXIT;
                        end else poll_cnt <= poll_cnt + 1'b1;
                    end else if ((each_q || last_blk) && ev_code != ERR_NONE) begin
                        err_q  <= ev_code;
                        fail_q <= cur_blk;
                        st     <= SQ_EXIT;
                    end else if (last_blk) begin
                        st <= SQ_EXIT;
                    end else begin
                        cur_blk   <= cur_blk + 1'b1;
                        remaining <= remaining - 1'b1;
                        st        <= SQ_SETUP;
                    end
                end
                SQ_EXIT: if (bus_ack) begin
                    pend      <= 1'b0;
                    done_q    <= 1'b1;
                    pass_q    <= (err_q == ERR_NONE);
                    owe_clear <= (err_q != ERR_NONE);
                    st        <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o     = (st != SQ_IDLE);
    assign done_o     = done_q;
    assign pass_o     = pass_q;
    assign err_o      = err_q;
    assign fail_blk_o = fail_q;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));
    p_poll_bound_r6: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < PC_W'(POLL_LIMIT));
    p_lock_first_r4: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_POLL && bus_ack && bus_rdata[7] && bus_rdata[1] && each_q)
        |=> (err_o == 3'd1));
    p_clear_first_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_o) && owe_clear) |-> (st == SQ_CLEAR));

endmodule

// File: tb/fbe_sequencer_test.sv
`timescale 1ns/1ps
module fbe_sequencer_test;
    localparam int ADDR_W = 21, DATA_W = 16, BLK_SHIFT = 15, CNT_W = 8;
    localparam int SETUP = 2, PULSE = 3, HOLD = 1, PLIM = 16;
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    typedef struct packed {
        logic [5:0] blk;
        logic [7:0] cnt;
        logic       each;
        logic [7:0] bad_off;
        logic [7:0] bad_bits;
        logic [7:0] busy;
        logic [2:0] exp_err;
        logic [5:0] exp_fail;
        logic [7:0] exp_n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{6'd3,  8'd1, 1'b1, 8'hFF, 8'h00, 8'd2,  3'd0, 6'd0,  8'd1},
        '{6'd10, 8'd3, 1'b1, 8'd1,  8'h20, 8'd3,  3'd3, 6'd11, 8'd2},
        '{6'd5,  8'd2, 1'b1, 8'hFF, 8'h00, 8'd1,  3'd0, 6'd0,  8'd2},
        '{6'd20, 8'd3, 1'b0, 8'd0,  8'h28, 8'd2,  3'd2, 6'd22, 8'd3},
        '{6'd40, 8'd2, 1'b1, 8'd0,  8'h2A, 8'd1,  3'd1, 6'd40, 8'd1},
        '{6'd1,  8'd1, 1'b1, 8'hFF, 8'h00, 8'd20, 3'd4, 6'd1,  8'd1},
        '{6'd63, 8'd0, 1'b1, 8'hFF, 8'h00, 8'd1,  3'd0, 6'd0,  8'd1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, each = 1'b1;
    logic [BLK_W-1:0] first_blk = '0;
    logic [CNT_W-1:0] blk_cnt = '0;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_dq_i, f_dq_o;
    logic f_dq_oe, f_ce_n, f_oe_n, f_we_n;
    logic busy, done, pass;
    logic [2:0] err;
    logic [BLK_W-1:0] fail_blk;

    always #2.5 clk = ~clk;

    fbe_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT), .CNT_W(CNT_W),
        .SETUP_CLKS(SETUP), .PULSE_CLKS(PULSE), .HOLD_CLKS(HOLD), .POLL_LIMIT(PLIM)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start), .first_blk_i(first_blk),
        .blk_cnt_i(blk_cnt), .check_each_i(each),
        .f_addr_o(f_addr), .f_dq_i(f_dq_i), .f_dq_o(f_dq_o), .f_dq_oe_o(f_dq_oe),
        .f_ce_n_o(f_ce_n), .f_oe_n_o(f_oe_n), .f_we_n_o(f_we_n),
        .busy_o(busy), .done_o(done), .pass_o(pass), .err_o(err),
        .fail_blk_o(fail_blk)
    );

    // Device model and bus monitor
    logic [15:0] m_status = 16'h0080;
    int m_busy = 0, busy_cfg = 1;
    logic armed = 1'b0;
    logic [5:0] arm_blk = '0, erase_blk = '0, start_blk = '0, inj_blk = '0;
    logic [7:0] inj_bits = '0;
    logic inj_on = 1'b0;
    int n_erase, n_clear, n_reads, n_writes, seq_bad, order_bad, timing_bad;
    logic [15:0] last_wr;
    logic we_prev = 1'b1, oe_prev = 1'b1;
    int scnt = 0, wlow = 0;

    assign f_dq_i = f_oe_n ? 16'h0000 : m_status;

    always @(negedge clk) begin
        if (!f_we_n && !f_oe_n) timing_bad++;
        if (!f_oe_n && !oe_prev && f_ce_n) timing_bad++;
        if (f_ce_n) scnt = 0;
        else if (f_we_n && !we_prev) begin
            if (wlow != PULSE) timing_bad++;
            scnt = 0;
            last_wr = f_dq_o;
            if (f_dq_o == 16'h0050) begin
                n_clear++;
                if (n_writes != 0) seq_bad++;
                m_status = m_status & ~16'h002A;
            end else if (f_dq_o == 16'h0020) begin
                armed = 1'b1;
                arm_blk = f_addr[20:15];
            end else if (f_dq_o == 16'h00D0) begin
                if (!armed || arm_blk != f_addr[20:15] || f_addr[14:0] != 15'd0) seq_bad++;
                if (f_addr[20:15] != 6'(start_blk + 6'(n_erase))) order_bad++;
                erase_blk = f_addr[20:15];
                n_erase++;
                m_busy = busy_cfg;
                m_status[7] = 1'b0;
                armed = 1'b0;
            end else armed = 1'b0;
            n_writes++;
        end else if (!f_we_n && we_prev) begin
            if (scnt != SETUP) timing_bad++;
            wlow = 1;
        end else if (!f_we_n) wlow++;
        else if (f_dq_oe) scnt++;
        if (f_oe_n && !oe_prev) begin
            n_reads++;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    m_status[7] = 1'b1;
                    if (inj_on && erase_blk == inj_blk) m_status[7:0] = m_status[7:0] | inj_bits;
                end
            end
        end
        we_prev = f_we_n;
        oe_prev = f_oe_n;
    end

    int n_chk = 0, n_fail = 0;
    logic finished = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic launch(input vec_t v);
        n_erase = 0; n_clear = 0; n_reads = 0; n_writes = 0;
        seq_bad = 0; order_bad = 0; timing_bad = 0; last_wr = 16'h0;
        start_blk = v.blk; busy_cfg = int'(v.busy);
        inj_on = (v.bad_off != 8'hFF);
        inj_blk = 6'(v.blk + v.bad_off[5:0]);
        inj_bits = v.bad_bits;
        @(negedge clk);
        first_blk = v.blk; blk_cnt = v.cnt; each = v.each; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int exp_clear);
        int exp_reads;
        launch(v);
        check("R9 busy after start", int'(busy), 1);
        while (!done) @(negedge clk);
        exp_reads = (v.exp_err == 3'd4) ? PLIM : int'(v.exp_n) * (int'(v.busy) + 1);
        check("R4/R5/R6 error code", int'(err), int'(v.exp_err));
        check("R9 pass flag", int'(pass), (v.exp_err == 3'd0) ? 1 : 0);
        check("R9 busy low at done", int'(busy), 0);
        if (v.exp_err != 3'd0) check("R4/R5/R6 failing block", int'(fail_blk), int'(v.exp_fail));
        check("R1/R5/R10 blocks erased", n_erase, int'(v.exp_n));
        check("R1 block order", order_bad, 0);
        check("R1 command pairing", seq_bad, 0);
        check("R2 status reads", n_reads, exp_reads);
        check("R7 final write", int'(last_wr), 16'h00FF);
        check("R8 clear-status writes", n_clear, exp_clear);
        check("R3 strobe timing", timing_bad, 0);
        @(negedge clk);
        check("R9 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        check("R9 code held", int'(err), int'(v.exp_err));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int prev_err;
        repeat (3) @(negedge clk);
        check("R11 ce_n reset", int'(f_ce_n), 1);
        check("R11 we_n reset", int'(f_we_n), 1);
        check("R11 oe_n reset", int'(f_oe_n), 1);
        check("R11 busy/done/pass/err reset",
              int'({busy, done, pass, err, f_dq_oe}), 0);
        rst = 1'b0;
        prev_err = 0;
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], (prev_err != 0) ? 1 : 0);
            prev_err = int'(VECS[i].exp_err);
        end
        // Reset in the middle of a long poll, then a clean run: no clear owed (R11).
        launch(VECS[5]);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 ce_n mid-run reset", int'(f_ce_n), 1);
        check("R11 busy/err mid-run reset", int'({busy, err, done}), 0);
        rst = 1'b0;
        run_vec(VECS[0], 0);
        summary();
    end

endmodule